// File: doc/BRIEF.md
# SIMD Shift-and-Accumulate Unit

This block is a vector integer datapath. Each lane of the second source is shifted by one immediate amount that all lanes share, and the shifted value is then added to or subtracted from the matching lane of the first source. Three shift kinds are supported: logical left, logical right and arithmetic right. Each kind can be paired with an add or a subtract, which gives six operations. The 512-bit vector can be split into lanes of 8, 16, 32 or 64 bits. Because the shift and the accumulate are fused into one lane operation, a kernel needs no separate shift step. It also needs fewer stored constants: a single all-ones vector, shifted, can supply any power of two or any low-bit mask as an addend.

A per-element write mask decides which lanes take the new result. An unselected lane either keeps the matching element of a merge operand, which holds the prior destination value, or is forced to zero. Operations enter with a single-cycle valid strobe. They pass through one register stage and come out with a matching valid. There is no back-pressure.

Top module: `simd_shacc`

## Requirements
- R1: After reset, valid_o and result_o are zero. valid_o equals valid_i delayed by one clock. result_o changes only in the cycle after a cycle with valid_i high, and otherwise holds its value.
- R2: With sub_i=0, each written lane gives src1 + shift(src2, amt_i), wrapping modulo 2^W with no saturation.
- R3: With sub_i=1, each written lane gives src1 − shift(src2, amt_i), wrapping modulo 2^W.
- R4: kind_i selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right (sign fill), and 3 behaves as logical left.
- R5: width_i selects the lane width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Lane k occupies bits [k*W +: W]. No carry or borrow crosses a lane boundary.
- R6: When amt_i is greater than or equal to the lane width, a logical shift yields zero. An arithmetic right shift yields every bit equal to the lane's sign bit.
- R7: Lane k is written when mask_i[k] is 1. When mask_i[k] is 0 and zero_i=0, the lane takes lane k of merge_i.
- R8: When mask_i[k] is 0 and zero_i=1, lane k of the result is zero.
- R9: Two constant tricks hold. Subtracting an all-ones lane shifted left by k adds 2^k. For 8-bit lanes, adding an all-ones byte shifted right logically by k adds 2^(8−k) − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| width_i | input | 2 | Lane width code |
| kind_i | input | 2 | Shift kind code |
| sub_i | input | 1 | 1 = subtract shifted value, 0 = add |
| amt_i | input | 7 | Shift amount, shared by all lanes |
| zero_i | input | 1 | 1 = masked-off lanes become zero, 0 = they merge |
| mask_i | input | 64 | Per-element write mask; bit k governs lane k |
| src1_i | input | 512 | Accumulator source |
| src2_i | input | 512 | Shifted source |
| merge_i | input | 512 | Prior destination value for merged lanes |
| valid_o | output | 1 | Result valid |
| result_o | output | 512 | Registered result vector |

## Verification
Every result is due exactly one clock edge after the edge that samples valid_i. The bench drives each operation on a falling edge and lets one rising edge pass. It compares valid_o and result_o on the following falling edge, when both registered values are settled. The bench then drops valid_i for one cycle and confirms on the next falling edge that valid_o is low and that result_o still holds the earlier value.

// File: rtl/simd_sa_pkg.sv
package simd_sa_pkg;
  localparam int VLEN  = 512;
  localparam int AMT_W = 7;
  localparam int NBYTE = VLEN / 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2
  } sh_kind_e;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;
endpackage

// File: rtl/simd_sa_lane.sv
module simd_sa_lane
  import simd_sa_pkg::*;
#(
  parameter int W    = 8,
  parameter int AW   = AMT_W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [AW-1:0] amt_i,
  input  logic [1:0]    kind_i,
  input  logic          sub_i,
  output logic [W-1:0]  y_o
);
  logic         over;
  logic [W-1:0] sh;

  assign over = 32'(amt_i) >= W;

  always_comb begin
    case (kind_i)
      SH_LSR:  sh = over ? '0 : (b_i >> amt_i);
      SH_ASR:  sh = over ? {W{b_i[W-1]}} : W'($signed(b_i) >>> amt_i);
      default: sh = over ? '0 : (b_i << amt_i);
    endcase
  end

  // lane-local add/sub: carries end at the lane edge
  assign y_o = sub_i ? (a_i - sh) : (a_i + sh);
endmodule

// File: rtl/simd_sa_merge.sv
module simd_sa_merge
  import simd_sa_pkg::*;
#(
  parameter int VL = VLEN,
  localparam int NB = VL / 8
) (
  input  logic [1:0]    width_i,
  input  logic [NB-1:0] mask_i,
  input  logic          zero_i,
  input  logic [VL-1:0] res_i,
  input  logic [VL-1:0] old_i,
  output logic [VL-1:0] y_o
);
  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic en;
    always_comb begin
      case (width_i)
        LW_8:    en = mask_i[j];
        LW_16:   en = mask_i[j/2];
        LW_32:   en = mask_i[j/4];
        default: en = mask_i[j/8];
      endcase
    end
    assign y_o[j*8 +: 8] = en ? res_i[j*8 +: 8] : (zero_i ? 8'h00 : old_i[j*8 +: 8]);
  end
endmodule

// File: rtl/simd_shacc.sv
module simd_shacc
  import simd_sa_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         width_i,
  input  logic [1:0]         kind_i,
  input  logic               sub_i,
  input  logic [AMT_W-1:0]   amt_i,
  input  logic               zero_i,
  input  logic [NBYTE-1:0]   mask_i,
  input  logic [VLEN-1:0]    src1_i,
  input  logic [VLEN-1:0]    src2_i,
  input  logic [VLEN-1:0]    merge_i,
  output logic               valid_o,
  output logic [VLEN-1:0]    result_o
);
  localparam int NWID = 4;

  logic [VLEN-1:0] res_w [NWID];
  logic [VLEN-1:0] res_sel;
  logic [VLEN-1:0] res_mrg;
  logic            valid_q;
  logic [VLEN-1:0] res_q;

  for (genvar gw = 0; gw < NWID; gw++) begin : g_w
    localparam int W = 8 << gw;
    localparam int N = VLEN / W;
    for (genvar l = 0; l < N; l++) begin : g_l
      simd_sa_lane #(.W(W), .AW(AMT_W)) i_lane (
        .a_i    (src1_i[l*W +: W]),
        .b_i    (src2_i[l*W +: W]),
        .amt_i  (amt_i),
        .kind_i (kind_i),
        .sub_i  (sub_i),
        .y_o    (res_w[gw][l*W +: W])
      );
    end
  end

  always_comb begin
    case (width_i)
      LW_8:    res_sel = res_w[0];
      LW_16:   res_sel = res_w[1];
      LW_32:   res_sel = res_w[2];
      default: res_sel = res_w[3];
    endcase
  end

  simd_sa_merge #(.VL(VLEN)) i_merge (
    .width_i (width_i),
    .mask_i  (mask_i),
    .zero_i  (zero_i),
    .res_i   (res_sel),
    .old_i   (merge_i),
    .y_o     (res_mrg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_mrg;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R1
  AST_ZERO_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zero_i && mask_i == '0) |=> result_o == '0); // R8
  AST_MERGE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero_i && mask_i == '0) |=> result_o == $past(merge_i)); // R7
  AST_WIDE_LOGICAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&mask_i) && kind_i != SH_ASR && 32'(amt_i) >= 64)
      |=> result_o == $past(src1_i)); // R6
endmodule

// File: tb/test_simd_shacc.sv
`timescale 1ns/1ps
module test_simd_shacc;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   width_i = '0;
  logic [1:0]   kind_i = '0;
  logic         sub_i = 1'b0;
  logic [6:0]   amt_i = '0;
  logic         zero_i = 1'b0;
  logic [63:0]  mask_i = '0;
  logic [511:0] src1_i = '0;
  logic [511:0] src2_i = '0;
  logic [511:0] merge_i = '0;
  logic         valid_o;
  logic [511:0] result_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  simd_shacc i_simd_shacc (
    .clk_i, .rst_ni, .valid_i, .width_i, .kind_i, .sub_i, .amt_i,
    .zero_i, .mask_i, .src1_i, .src2_i, .merge_i, .valid_o, .result_o
  );

  function automatic logic [511:0] model(int w, logic [1:0] k, logic s, int amt, logic z,
                                         logic [63:0] m, logic [511:0] a, logic [511:0] b,
                                         logic [511:0] old);
    int W = 8 << w;
    logic [63:0] msk = (W == 64) ? '1 : ((64'd1 << W) - 64'd1);
    logic [63:0] av, bv, ov, sh, r;
    logic sign;
    logic [511:0] res = '0;
    for (int e = 0; e < 512 / W; e++) begin
      av = 64'(a >> (e * W)) & msk;
      bv = 64'(b >> (e * W)) & msk;
      ov = 64'(old >> (e * W)) & msk;
      sign = bv[W-1];
      case (k)
        2'd1: sh = (amt >= W) ? 64'd0 : (bv >> amt);
        2'd2: begin
          if (amt >= W) sh = sign ? msk : 64'd0;
          else sh = (bv >> amt) | (sign ? (msk & ~(msk >> amt)) : 64'd0);
        end
        default: sh = (amt >= W) ? 64'd0 : ((bv << amt) & msk);
      endcase
      r = (s ? (av - sh) : (av + sh)) & msk;
      if (!m[e]) r = z ? 64'd0 : ov;
      res = res | (512'(r) << (e * W));
    end
    return res;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(logic ok, string tag, logic [511:0] act, logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(int w, logic [1:0] k, logic s, int amt, logic z, logic [63:0] m,
                     logic [511:0] a, logic [511:0] b, logic [511:0] old,
                     logic [511:0] exp, string tag);
    logic [511:0] held;
    @(negedge clk_i);
    valid_i = 1'b1; width_i = 2'(w); kind_i = k; sub_i = s; amt_i = 7'(amt);
    zero_i = z; mask_i = m; src1_i = a; src2_i = b; merge_i = old;
    @(negedge clk_i);
    check(valid_o === 1'b1 && result_o === exp, tag, result_o, exp);
    held = result_o;
    valid_i = 1'b0;
    src1_i = rnd512(); src2_i = rnd512(); merge_i = rnd512();
    @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === held, "R1 hold", result_o, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] a, b, o, e;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === '0, "R1 reset", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === '0, "R1 after reset", result_o, '0);

    // R5 carry isolation: 0xFF + 1 per byte -> 0x00 in every byte
    run(0, 2'd0, 1'b0, 0, 1'b0, '1, '1, {64{8'h01}}, '0, '0, "R5 carry");
    // R5 16-bit lanes: 0xFFFF + 1 -> 0
    run(1, 2'd0, 1'b0, 0, 1'b0, '1, '1, {32{16'h0001}}, '0, '0, "R5 carry16");
    // R3 borrow isolation: 0 - 1 per 32-bit lane -> all ones
    run(2, 2'd1, 1'b1, 0, 1'b0, '1, '0, {16{32'h1}}, '0, '1, "R3 borrow");
    // R9 subtract all-ones << 3 adds 8
    a = rnd512();
    for (int i = 0; i < 64; i++) e[i*8 +: 8] = a[i*8 +: 8] + 8'd8;
    run(0, 2'd0, 1'b1, 3, 1'b0, '1, a, '1, '0, e, "R9 pow2");
    // R9 add all-ones >> 5 adds 7
    a = rnd512();
    for (int i = 0; i < 64; i++) e[i*8 +: 8] = a[i*8 +: 8] + 8'd7;
    run(0, 2'd1, 1'b0, 5, 1'b0, '1, a, '1, '0, e, "R9 lowmask");
    // R4 arithmetic right on negative 16-bit: 0 + (0x8000 >>> 15) = 0xFFFF
    run(1, 2'd2, 1'b0, 15, 1'b0, '1, '0, {32{16'h8000}}, '0, '1, "R4 asr");
    // R4 code 3 behaves as logical left
    a = rnd512(); b = rnd512();
    run(3, 2'd3, 1'b0, 5, 1'b0, '1, a, b, '0, model(3, 2'd0, 1'b0, 5, 1'b0, '1, a, b, '0), "R4 code3");
    // R6 wide shifts
    a = rnd512();
    run(2, 2'd1, 1'b0, 40, 1'b0, '1, a, '1, '0, a, "R6 lsr wide");
    run(0, 2'd2, 1'b0, 9, 1'b0, '1, '0, {64{8'h80}}, '0, '1, "R6 asr wide");
    run(3, 2'd0, 1'b1, 100, 1'b0, '1, a, '1, '0, a, "R6 lsl wide");
    // R7 merge and R8 zero
    a = rnd512(); b = rnd512(); o = rnd512();
    run(0, 2'd0, 1'b0, 1, 1'b0, 64'h0, a, b, o, o, "R7 merge all");
    run(0, 2'd0, 1'b0, 1, 1'b1, 64'h0, a, b, o, '0, "R8 zero all");
    run(1, 2'd1, 1'b0, 2, 1'b0, 64'hA5A5_5A5A, a, b, o,
        model(1, 2'd1, 1'b0, 2, 1'b0, 64'hA5A5_5A5A, a, b, o), "R7 merge part");
    run(2, 2'd2, 1'b1, 3, 1'b1, 64'h0000_0000_0000_9C63, a, b, o,
        model(2, 2'd2, 1'b1, 3, 1'b1, 64'h9C63, a, b, o), "R8 zero part");

    // random mix: R2 (add) / R3 (sub)
    for (int t = 0; t < 400; t++) begin
      int w, amt;
      logic [1:0] k;
      logic s, z;
      logic [63:0] m;
      w = int'($urandom % 4);
      k = 2'($urandom % 4);
      s = 1'($urandom);
      z = 1'($urandom);
      amt = ($urandom % 4 == 0) ? int'($urandom % 128) : int'($urandom % ((8 << w) + 1));
      m = {$urandom, $urandom};
      if (t % 5 == 0) m = '1;
      a = rnd512(); b = rnd512(); o = rnd512();
      run(w, k, s, amt, z, m, a, b, o, model(w, k, s, amt, z, m, a, b, o),
          s ? "R3 random" : "R2 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule